// File: doc/BRIEF.md
# Single-Cycle Integer ALU with Carry-Select Adder and 4:2 Compressor Multiplier

This block is the execute stage of a small non-pipelined processor core. It takes two 16-bit operands, a 4-bit operation code and a shift distance. In one clock it produces a result word together with a sign flag and a zero flag, ready for write-back to the destination register. The datapath has three sections.

- An arithmetic section holds a carry-select adder and a multiplier that reduces its partial-product rows with 4:2 compressors.
- A logic section computes AND, OR and XOR.
- A barrel section shifts or rotates the first operand.

The operands, the code and the distance are sampled on a rising edge. The result and both flags appear together from the same set of registers after that edge. The block has no carry-out flag. Any carry beyond bit 15 is dropped.

Top module: `sc_alu`

## Requirements
- R1: Code 0 (add) gives (A + B) mod 2^16. The carry out of bit 15 is discarded, so 0xFFFF + 0x0001 gives 0x0000.
- R2: Code 1 (multiply) gives the low 16 bits of the unsigned 32-bit product A × B.
- R3: Code 2 gives A AND B, code 3 gives A OR B, and code 4 gives A XOR B.
- R4: Code 5 shifts A left by the distance (0 to 15) and fills the vacated low bits with zeros.
- R5: Code 6 shifts A right arithmetically by the distance and copies bit 15 into the vacated high bits. A distance of one gives the floor of A/2 for signed A (0xFFFA becomes 0xFFFD, and 0xFFFB also becomes 0xFFFD).
- R6: Code 7 rotates A left and code 8 rotates A right by the distance. Bits leaving one end re-enter at the other end. A distance of 0 returns A unchanged.
- R7: The zero flag is 1 exactly when all 16 result bits are 0, for every code.
- R8: The sign flag equals result bit 15, for every code.
- R9: The result and both flags change only on a rising clock edge. They reflect the inputs sampled at that edge.
- R10: While rst_n is low, the result is 0x0000, the sign flag is 0 and the zero flag is 1.
- R11: Codes 9 to 15 are unassigned and give a result of 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low asynchronous reset |
| opnd_a | input | 16 | First operand; the value that is shifted or rotated |
| opnd_b | input | 16 | Second operand |
| op_sel | input | 4 | Operation code (see requirements) |
| shamt | input | 4 | Shift or rotate distance |
| result | output | 16 | Registered result word |
| flag_sign | output | 1 | Registered sign flag |
| flag_zero | output | 1 | Registered zero flag |

## Verification
The bench builds the block at its default parameters: a 16-bit word, 4-bit carry-select blocks and therefore a three-level compressor tree that reduces 16 rows to 2. At this width every shift distance from 0 to 15 and every operation code, including the seven unassigned ones, can be driven directly. A behavioural model computes the expected result with plain integer arithmetic and compares it on every clock. Directed vectors cover carry wrap, all-ones products, sign-fill on odd and even negatives, and rotation by zero. A long run of random vectors then exercises carry propagation across all four adder blocks.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_MUL = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SLL = 4'd5,
        OP_SRA = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LL = 2'd0,
        SH_RA = 2'd1,
        SH_RL = 2'd2,
        SH_RR = 2'd3
    } sh_mode_e;

endpackage

// File: rtl/csel_adder.sv
module csel_adder #(
    parameter int WIDTH = 16,
    parameter int BLK   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] sum_o
);
    localparam int NB = WIDTH / BLK;

    logic cy [NB];
    assign cy[0] = 1'b0;

    for (genvar k = 0; k < NB; k++) begin : g_blk
        logic [BLK-1:0] ab, bb;
        assign ab = a_i[k*BLK +: BLK];
        assign bb = b_i[k*BLK +: BLK];
        if (k == NB-1) begin : g_last
            logic [BLK-1:0] r0, r1;
            assign r0 = ab + bb;
            assign r1 = ab + bb + BLK'(1);
            assign sum_o[k*BLK +: BLK] = cy[k] ? r1 : r0;
        end else begin : g_mid
            logic [BLK:0] r0, r1;
            assign r0 = {1'b0, ab} + {1'b0, bb};
            assign r1 = {1'b0, ab} + {1'b0, bb} + (BLK+1)'(1);
            assign sum_o[k*BLK +: BLK] = cy[k] ? r1[BLK-1:0] : r0[BLK-1:0];
            assign cy[k+1] = cy[k] ? r1[BLK] : r0[BLK];
        end
    end
endmodule

// File: rtl/comp_mult.sv
module comp_mult #(
    parameter int WIDTH = 16,
    parameter int BLK   = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] prod_o
);
    localparam int LEVELS = $clog2(WIDTH) - 1;

    function automatic logic [2*WIDTH-1:0] cmp42(
        input logic [WIDTH-1:0] x, input logic [WIDTH-1:0] y,
        input logic [WIDTH-1:0] z, input logic [WIDTH-1:0] w);
        logic [WIDTH-1:0] so, co;
        logic s1, c1, ci;
        ci = 1'b0;
        for (int j = 0; j < WIDTH; j++) begin
            s1    = x[j] ^ y[j] ^ z[j];
            c1    = (x[j] & y[j]) | (x[j] & z[j]) | (y[j] & z[j]);
            so[j] = s1 ^ w[j] ^ ci;
            co[j] = (s1 & w[j]) | (s1 & ci) | (w[j] & ci);
            ci    = c1;
        end
        return {so, co[WIDTH-2:0], 1'b0};
    endfunction

    for (genvar l = 0; l <= LEVELS; l++) begin : stg
        localparam int N = WIDTH >> l;
        logic [WIDTH-1:0] rows [N];
        if (l == 0) begin : g_pp
            for (genvar i = 0; i < N; i++) begin : g_row
                assign rows[i] = b_i[i] ? (a_i << i) : '0;
            end
        end else begin : g_red
            for (genvar g = 0; g < N/2; g++) begin : g_grp
                assign {rows[2*g], rows[2*g+1]} =
                    cmp42(stg[l-1].rows[4*g],   stg[l-1].rows[4*g+1],
                          stg[l-1].rows[4*g+2], stg[l-1].rows[4*g+3]);
            end
        end
    end

    csel_adder #(.WIDTH(WIDTH), .BLK(BLK)) fin_add_i (
        .a_i  (stg[LEVELS].rows[0]),
        .b_i  (stg[LEVELS].rows[1]),
        .sum_o(prod_o)
    );
endmodule

// File: rtl/shift_rot.sv
module shift_rot
    import sc_alu_pkg::*;
#(
    parameter int WIDTH = 16,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] val_i,
    input  logic [SHW-1:0]   amt_i,
    input  sh_mode_e         mode_i,
    output logic [WIDTH-1:0] val_o
);
    logic [WIDTH-1:0] st [SHW+1];
    assign st[0] = val_i;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        logic [WIDTH-1:0] moved;
        always_comb begin
            unique case (mode_i)
                SH_LL:   moved = st[s] << D;
                SH_RA:   moved = WIDTH'($signed(st[s]) >>> D);
                SH_RL:   moved = {st[s][WIDTH-1-D:0], st[s][WIDTH-1:WIDTH-D]};
                default: moved = {st[s][D-1:0], st[s][WIDTH-1:D]};
            endcase
        end
        assign st[s+1] = amt_i[s] ? moved : st[s];
    end

    assign val_o = st[SHW];
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_alu_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int BLK   = 4,
    localparam int SHW  = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    input  logic [3:0]       op_sel,
    input  logic [SHW-1:0]   shamt,
    output logic [WIDTH-1:0] result,
    output logic             flag_sign,
    output logic             flag_zero
);
    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             sgn;
        logic             zro;
    } wb_t;

    wb_t wb_d, wb_q;
    logic [WIDTH-1:0] sum_w, prod_w, shf_w;
    sh_mode_e         mode_w;

    csel_adder #(.WIDTH(WIDTH), .BLK(BLK)) add_i (
        .a_i(opnd_a), .b_i(opnd_b), .sum_o(sum_w));

    comp_mult #(.WIDTH(WIDTH), .BLK(BLK)) mul_i (
        .a_i(opnd_a), .b_i(opnd_b), .prod_o(prod_w));

    always_comb begin
        unique case (op_sel)
            OP_SRA:  mode_w = SH_RA;
            OP_ROL:  mode_w = SH_RL;
            OP_ROR:  mode_w = SH_RR;
            default: mode_w = SH_LL;
        endcase
    end

    shift_rot #(.WIDTH(WIDTH)) shf_i (
        .val_i(opnd_a), .amt_i(shamt), .mode_i(mode_w), .val_o(shf_w));

    always_comb begin
        wb_d = '0;
        case (op_sel)
            OP_ADD:                         wb_d.res = sum_w;
            OP_MUL:                         wb_d.res = prod_w;
            OP_AND:                         wb_d.res = opnd_a & opnd_b;
            OP_OR:                          wb_d.res = opnd_a | opnd_b;
            OP_XOR:                         wb_d.res = opnd_a ^ opnd_b;
            OP_SLL, OP_SRA, OP_ROL, OP_ROR: wb_d.res = shf_w;
            default:                        wb_d.res = '0;
        endcase
        wb_d.sgn = wb_d.res[WIDTH-1];
        wb_d.zro = (wb_d.res == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wb_q <= '{res: '0, sgn: 1'b0, zro: 1'b1};
        else        wb_q <= wb_d;
    end

    assign result    = wb_q.res;
    assign flag_sign = wb_q.sgn;
    assign flag_zero = wb_q.zro;

    // R1
    add_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_ADD) |=> (result == WIDTH'($past(opnd_a) + $past(opnd_b))));
    // R2
    mul_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_MUL) |=> (result == WIDTH'($past(opnd_a) * $past(opnd_b))));
    // R3
    xor_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_XOR) |=> (result == ($past(opnd_a) ^ $past(opnd_b))));
    // R5
    half_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel == OP_SRA && shamt == SHW'(1)) |=>
        (result == {$past(opnd_a[WIDTH-1]), $past(opnd_a[WIDTH-1:1])}));
    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_zero == (result == '0));
    // R8
    sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_sign == result[WIDTH-1]);
    // R11
    spare_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel > 4'd8) |=> (result == '0));
endmodule

// File: tb/sc_alu_tb_top.sv
module sc_alu_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] opnd_a = '0, opnd_b = '0;
    logic [3:0]  op_sel = '0, shamt = '0;
    logic [15:0] result;
    logic        flag_sign, flag_zero;

    int total = 0, bad = 0;
    bit done = 1'b0;
    logic [15:0] exp_prev = 16'h0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    sc_alu dut_i (
        .clk(clk), .rst_n(rst_n), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .op_sel(op_sel), .shamt(shamt), .result(result),
        .flag_sign(flag_sign), .flag_zero(flag_zero));

    function automatic logic [15:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input int op, input int sh);
        case (op)
            0: return a + b;
            1: return a * b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return a << sh;
            6: return 16'($signed(a) >>> sh);
            7: return (sh == 0) ? a : ((a << sh) | (a >> (16 - sh)));
            8: return (sh == 0) ? a : ((a >> sh) | (a << (16 - sh)));
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            6: return "R5";
            7, 8: return "R6";
            default: return "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] a, input logic [15:0] b,
                        input int op, input int sh);
        logic [15:0] e;
        opnd_a = a; opnd_b = b; op_sel = 4'(op); shamt = 4'(sh);
        #1;
        check("R9", result, exp_prev);   // no change before the edge
        @(posedge clk); #1;
        e = model(a, b, op, sh);
        check(req_of(op), result, e);
        check("R8", {15'd0, flag_sign}, {15'd0, e[15]});
        check("R7", {15'd0, flag_zero}, {15'd0, (e == 16'h0000)});
        exp_prev = e;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        opnd_a = 16'h1234; opnd_b = 16'h4321; op_sel = 4'd0;
        repeat (3) @(posedge clk);
        #1;
        // R10 reset state
        check("R10", result, 16'h0000);
        check("R10", {15'd0, flag_sign}, 16'h0000);
        check("R10", {15'd0, flag_zero}, 16'h0001);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        exp_prev = model(16'h1234, 16'h4321, 0, 0);

        step(16'hFFFF, 16'h0001, 0, 0);   // R1 carry dropped, R7 zero
        step(16'h7FFF, 16'h0001, 0, 0);   // R1, R8 sign
        step(16'h1234, 16'h5678, 1, 0);   // R2
        step(16'hFFFF, 16'hFFFF, 1, 0);   // R2 -> 0x0001
        step(16'h0100, 16'h0100, 1, 0);   // R2 overflow to zero
        step(16'hF0F0, 16'h3C3C, 2, 0);   // R3
        step(16'hF0F0, 16'h3C3C, 3, 0);   // R3
        step(16'hA5A5, 16'hA5A5, 4, 0);   // R3 zero result
        step(16'h8001, 16'h0000, 5, 15);  // R4
        step(16'h00FF, 16'h0000, 5, 0);   // R4 distance 0
        step(16'hFFFA, 16'h0000, 6, 1);   // R5 -> 0xFFFD
        step(16'hFFFB, 16'h0000, 6, 1);   // R5 -> 0xFFFD
        step(16'h4000, 16'h0000, 6, 15);  // R5 -> 0
        step(16'h8000, 16'h0000, 6, 15);  // R5 -> 0xFFFF
        step(16'h8001, 16'h0000, 7, 1);   // R6 -> 0x0003
        step(16'h0001, 16'h0000, 8, 1);   // R6 -> 0x8000
        step(16'h1234, 16'h0000, 8, 0);   // R6 distance 0
        step(16'hBEEF, 16'h1111, 9, 3);   // R11
        step(16'hBEEF, 16'h1111, 15, 3);  // R11

        for (int i = 0; i < 2000; i++) begin
            step(16'($urandom), 16'($urandom), int'($urandom % 12), int'($urandom % 16));
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule